// File: doc/BRIEF.md
# Bidirectional AES-128 Round Key Generator

This block produces the AES-128 key schedule one round key per clock cycle, in either direction. In forward mode a cipher key is loaded and appears as round key 0; each step strobe then expands it by one round, up to round 10. An iterative encryption datapath that runs one round per cycle can use this order directly.

In reverse mode the final (round 10) key is loaded instead. Each step rebuilds the round key before it, down to the cipher key at round 0. This order feeds an iterative decryption datapath without storing the eleven-key schedule.

The direction is sampled only on a load and is held until the next load. The S-box used by SubWord is computed with logic: a GF(2^8) inversion followed by the affine map. There is no lookup table.

Top module: `aes_kgen`

## Requirements
- R1: When rst_ni is low, rkey_o is all zeros, round_o is 0 and the mode is forward.
- R2: A load with dir_i=0 makes rkey_o equal key_i and round_o equal 0 on the next cycle. A load with dir_i=1 makes rkey_o equal key_i and round_o equal 10. In both cases the value of dir_i is kept as the mode.
- R3: A forward step from round r < 10 sets round_o to r+1. The new key is built from the 32-bit words w0..w3 of the current key, where w0 is bits [127:96]. Let t = SubWord(RotWord(w3)) XOR {rcon(r+1), 24'h0}. Then n0 = w0^t, n1 = w1^n0, n2 = w2^n1 and n3 = w3^n2.
- R4: A reverse step from round r > 0 sets round_o to r-1. Starting from words n0..n3, it computes w3 = n3^n2, w2 = n2^n1 and w1 = n1^n0. Then w0 = n0 ^ SubWord(RotWord(w3)) ^ {rcon(r), 24'h0}.
- R5: RotWord moves the top byte of the word to the bottom byte. SubWord applies the AES S-box to each byte. rcon(1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R6: Ten forward steps from key 000102030405060708090a0b0c0d0e0f give 13111d7fe3944a17f307a78b4d2b30c5. Ten reverse steps from that value give the cipher key back.
- R7: A step at round 10 in forward mode, or at round 0 in reverse mode, is ignored. Key and round hold their values.
- R8: When load_i and step_i are both high in the same cycle, only the load takes effect.
- R9: With neither load_i nor step_i high, key and round hold. A change of dir_i without a load does not change the step direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load key_i and take the mode from dir_i |
| key_i | input | 128 | Cipher key (forward) or round-10 key (reverse) |
| dir_i | input | 1 | 0 = forward, 1 = reverse; sampled on load |
| step_i | input | 1 | Advance one round in the loaded direction |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the current round key |

## Verification
Every load or step shows on rkey_o and round_o in the cycle right after the clock edge that samples it. There is exactly one register stage and nothing combinational in the output path. The driver applies one stimulus per cycle on the falling edge and pushes the expected key and round for that cycle. The monitor pops and compares one entry just after each rising edge, so each result is checked in the cycle it becomes due. The expected keys come from the bench's own S-box, built from log and exponent tables, and its own forward and inverse expansion.

// File: rtl/aes_kgen_pkg.sv
package aes_kgen_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int KEY_W   = WORD_W * NWORDS;
  localparam int LAST_RD = 10;
  localparam int ROUND_W = $clog2(LAST_RD + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [ROUND_W-1:0] round_t;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc, aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
    end
    return acc;
  endfunction

  function automatic byte_t rcon(round_t r);
    case (r)
      4'd1:  return 8'h01;
      4'd2:  return 8'h02;
      4'd3:  return 8'h04;
      4'd4:  return 8'h08;
      4'd5:  return 8'h10;
      4'd6:  return 8'h20;
      4'd7:  return 8'h40;
      4'd8:  return 8'h80;
      4'd9:  return 8'h1b;
      4'd10: return 8'h36;
      default: return 8'h00;
    endcase
  endfunction

  function automatic word_t rot_word(word_t w);
    return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1:WORD_W-BYTE_W]};
  endfunction
endpackage

// File: rtl/aes_kgen_sbox.sv
module aes_kgen_sbox
  import aes_kgen_pkg::*;
(
  input  byte_t a_i,
  output byte_t s_o
);
  byte_t inv;
  byte_t sq;

  // a^254 = a^2 * a^4 * ... * a^128 (0 maps to 0)
  always_comb begin
    sq  = gf_mul(a_i, a_i);
    inv = sq;
    for (int i = 2; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
  end

  // affine map
  always_comb begin
    s_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aes_kgen_subword.sv
module aes_kgen_subword
  import aes_kgen_pkg::*;
(
  input  word_t w_i,
  output word_t w_o
);
  localparam int NB = WORD_W / BYTE_W;

  for (genvar g = 0; g < NB; g++) begin : g_sbox
    aes_kgen_sbox u_sbox (
      .a_i(w_i[g*BYTE_W +: BYTE_W]),
      .s_o(w_o[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aes_kgen_step.sv
module aes_kgen_step
  import aes_kgen_pkg::*;
(
  input  key_t   key_i,
  input  round_t round_i,
  input  logic   rev_i,
  output key_t   key_o
);
  word_t  w [NWORDS];
  word_t  o [NWORDS];
  word_t  sel, sub, t;
  round_t rc_idx;

  for (genvar g = 0; g < NWORDS; g++) begin : g_split
    assign w[g] = key_i[KEY_W-1-g*WORD_W -: WORD_W];
    assign key_o[KEY_W-1-g*WORD_W -: WORD_W] = o[g];
  end

  // one SubWord shared by both directions
  assign sel    = rev_i ? (w[NWORDS-1] ^ w[NWORDS-2]) : w[NWORDS-1];
  assign rc_idx = rev_i ? round_i : round_i + round_t'(1);

  aes_kgen_subword u_sub (
    .w_i(rot_word(sel)),
    .w_o(sub)
  );

  assign t = sub ^ {rcon(rc_idx), {(WORD_W-BYTE_W){1'b0}}};

  always_comb begin
    if (rev_i) begin
      o[0] = w[0] ^ t;
      for (int i = 1; i < NWORDS; i++) o[i] = w[i] ^ w[i-1];
    end else begin
      o[0] = w[0] ^ t;
      for (int i = 1; i < NWORDS; i++) o[i] = w[i] ^ o[i-1];
    end
  end
endmodule

// File: rtl/aes_kgen.sv
module aes_kgen
  import aes_kgen_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [127:0] key_i,
  input  logic         dir_i,
  input  logic         step_i,
  output logic [127:0] rkey_o,
  output logic [3:0]   round_o
);
  key_t   key_q, key_nxt;
  round_t round_q;
  logic   rev_q;
  logic   can_fwd, can_rev, adv;

  aes_kgen_step u_step (
    .key_i  (key_q),
    .round_i(round_q),
    .rev_i  (rev_q),
    .key_o  (key_nxt)
  );

  assign can_fwd = !rev_q && (round_q < round_t'(LAST_RD));
  assign can_rev = rev_q && (round_q != '0);
  assign adv     = step_i && !load_i && (can_fwd || can_rev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      round_q <= '0;
      rev_q   <= 1'b0;
    end else if (load_i) begin
      key_q   <= key_i;
      rev_q   <= dir_i;
      round_q <= dir_i ? round_t'(LAST_RD) : '0;
    end else if (adv) begin
      key_q   <= key_nxt;
      round_q <= rev_q ? round_q - round_t'(1) : round_q + round_t'(1);
    end
  end

  assign rkey_o  = key_q;
  assign round_o = round_q;

  p_round_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_o <= 4'(LAST_RD));

  p_load_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rkey_o == $past(key_i)) &&
               (round_o == ($past(dir_i) ? 4'(LAST_RD) : 4'd0)));

  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i && !dir_i) |=> round_o == 4'd0);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(rkey_o) && $stable(round_o));

  p_fwd_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !rev_q && round_o == 4'(LAST_RD)) |=> $stable(rkey_o));

  p_fwd_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !rev_q && round_o < 4'(LAST_RD)) |=>
      (round_o == $past(round_o) + 4'd1) &&
      ((rkey_o[63:32] ^ rkey_o[31:0]) == $past(rkey_o[31:0])));

  p_rev_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && rev_q && round_o != 4'd0) |=>
      (round_o == $past(round_o) - 4'd1) &&
      (rkey_o[31:0] == ($past(rkey_o[31:0]) ^ $past(rkey_o[63:32]))));
endmodule

// File: tb/aes_kgen_bench.sv
module aes_kgen_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         dir_i = 1'b0;
  logic         step_i = 1'b0;
  logic [127:0] rkey_o;
  logic [3:0]   round_o;

  aes_kgen u_aes_kgen (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [127:0] key;
    logic [3:0]   rnd;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench S-box from log/exp tables, generator 3
  logic [7:0] ex_t [256];
  int         lg_t [256];
  logic [7:0] rc_t [11];

  function automatic logic [7:0] xt(logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] sb(logic [7:0] a);
    logic [7:0] v, s;
    v = (a == 0) ? 8'h00 : ex_t[(255 - lg_t[a]) % 255];
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return s;
  endfunction

  function automatic logic [31:0] g_fn(logic [31:0] w, int r);
    logic [31:0] x;
    x = {w[23:0], w[31:24]};
    return {sb(x[31:24]) ^ rc_t[r], sb(x[23:16]), sb(x[15:8]), sb(x[7:0])};
  endfunction

  function automatic logic [127:0] m_fwd(logic [127:0] k, int r);
    logic [31:0] a, b, c, d;
    a = k[127:96] ^ g_fn(k[31:0], r);
    b = k[95:64] ^ a;
    c = k[63:32] ^ b;
    d = k[31:0] ^ c;
    return {a, b, c, d};
  endfunction

  function automatic logic [127:0] m_rev(logic [127:0] k, int r);
    logic [31:0] a, b, c, d;
    d = k[31:0] ^ k[63:32];
    c = k[63:32] ^ k[95:64];
    b = k[95:64] ^ k[127:96];
    a = k[127:96] ^ g_fn(d, r);
    return {a, b, c, d};
  endfunction

  logic [127:0] m_key = '0;
  int           m_rnd = 0;
  bit           m_rev_mode = 0;

  task automatic drive(bit ld, bit dr, logic [127:0] k, bit st, string tag);
    exp_t e;
    string req;
    load_i = ld; dir_i = dr; key_i = k; step_i = st;
    req = tag;
    if (ld) begin
      m_key = k; m_rev_mode = dr; m_rnd = dr ? 10 : 0;
      if (req == "") req = st ? "R8" : "R2";
    end else if (st) begin
      if (!m_rev_mode && m_rnd < 10) begin
        m_key = m_fwd(m_key, m_rnd + 1); m_rnd++;
        if (req == "") req = "R3";
      end else if (m_rev_mode && m_rnd > 0) begin
        m_key = m_rev(m_key, m_rnd); m_rnd--;
        if (req == "") req = "R4";
      end else if (req == "") req = "R7";
    end else if (req == "") req = "R9";
    e.key = m_key; e.rnd = 4'(m_rnd); e.req = req;
    exp_q.push_back(e);
    @(negedge clk_i);
  endtask

  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (rkey_o !== e.key || round_o !== e.rnd) begin
        n_fail++;
        $display("FAIL %s: key %h round %0d, expected key %h round %0d",
                 e.req, rkey_o, round_o, e.key, e.rnd);
      end
    end
  end

  task automatic check_key(logic [127:0] want, string req);
    n_run++;
    if (rkey_o !== want) begin
      n_fail++;
      $display("FAIL %s: key %h, expected %h", req, rkey_o, want);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: timeout, expected completion");
    finish_run();
  end

  localparam logic [127:0] CK  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] K10 = 128'h13111d7fe3944a17f307a78b4d2b30c5;

  initial begin
    ex_t[0] = 8'h01;
    for (int i = 1; i < 256; i++) ex_t[i] = ex_t[i-1] ^ xt(ex_t[i-1]);
    for (int i = 0; i < 256; i++) lg_t[i] = 0;
    for (int i = 0; i < 255; i++) lg_t[ex_t[i]] = i;
    rc_t[0] = 8'h00; rc_t[1] = 8'h01;
    for (int i = 2; i < 11; i++) rc_t[i] = xt(rc_t[i-1]);

    #(CLK_PERIOD * 2 + 2);
    n_run++;
    if (rkey_o !== '0 || round_o !== 4'd0) begin
      n_fail++;
      $display("FAIL R1: key %h round %0d, expected 0 round 0", rkey_o, round_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // forward expansion of the reference key, R5 rcon values included
    drive(1, 0, CK, 0, "R2");
    for (int i = 0; i < 10; i++) drive(0, 0, '0, 1, "R5");
    check_key(K10, "R6");
    drive(0, 0, '0, 1, "R7");
    drive(0, 1, '0, 0, "R9");
    drive(0, 1, '0, 1, "R7");

    // reverse from round 10 back to the cipher key
    drive(1, 1, K10, 0, "R2");
    for (int i = 0; i < 10; i++) drive(0, 0, '0, 1, "R4");
    check_key(CK, "R6");
    drive(0, 1, '0, 1, "R7");
    drive(0, 0, '0, 1, "R9");

    // load wins over step
    drive(1, 0, 128'hffffffffffffffffffffffffffffffff, 1, "R8");
    drive(0, 0, '0, 1, "R3");
    drive(1, 1, 128'h0, 1, "R8");
    drive(0, 0, '0, 0, "R9");

    // several key patterns, steps interleaved with idle cycles
    for (int p = 0; p < 4; p++) begin
      logic [127:0] k;
      k = {4{32'h9e3779b9 * (p + 1)}} ^ {p[7:0], 120'h0};
      drive(1, 0, k, 0, "");
      for (int i = 0; i < 12; i++) drive(0, 0, '0, (i % 3) != 2, "");
      drive(1, 1, m_key, 0, "");
      for (int i = 0; i < 12; i++) drive(0, 1, '0, (i % 4) != 1, "");
    end

    drive(0, 0, '0, 0, "R9");
    @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule